// File: doc/BRIEF.md
# UART Interrupt Identification and Enable Logic

This block gathers the interrupt requests of a UART and presents them to a host processor. Seven sources each deliver a one-cycle event pulse: receive line status, receive data available, character time-out, transmit holding register empty, modem status (a change on the clear-to-send input), auto-baud time-out and auto-baud completion. Each pulse sets a sticky pending flag. The flag stays set until the source's clear input is pulsed. The transmit-empty flag is also cleared when the host reads the identification register while that source is the one reported.

An enable register masks the sources. A priority resolver turns the enabled pending flags into a read-only identification word. The word holds an active-low "nothing pending" flag, a 3-bit source code and two auto-baud status bits. The identification word sits in a snapshot register that stays frozen while the host holds a read of it. Events that arrive during the read still set their flags and show up on the next read. The interrupt output follows the snapshot.

The host port is a plain register port with a combinational read mux. It has no back-pressure: a read returns data in the same cycle as the strobe, and a write takes effect at the next clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification register reads 0x001, the enable register reads 0 and `irq` is low.
- R2: A pulse on `src_evt[i]` sets pending flag i, which stays set until `src_clr[i]` is pulsed. The indices are 0 line status, 1 data available, 2 character time-out, 3 transmit empty, 4 modem status, 5 auto-baud time-out and 6 auto-baud done. An event and a clear in the same cycle leave the flag set.
- R3: The enable register is at address 0, and only enabled pending sources are reported. The enable bits are: bit 0 for data available and character time-out, bit 1 for transmit empty, bit 2 for line status and bit 3 for modem status.
- R4: Identification bits 3:1 carry the code of the highest enabled pending source. From highest priority down, the codes are: line status 011, data available 010, character time-out 110, transmit empty 001 and modem status 000. The code is 000 when none of these five is reported.
- R5: Identification bit 0 is 0 when any enabled source is pending and 1 otherwise. `irq` is always the inverse of that bit.
- R6: While `rd_en` is held at address 1, the identification value and `irq` do not change.
- R7: An event that arrives during an identification read is kept and is reported by the next read.
- R8: The first cycle of an identification read clears the transmit-empty flag only if code 001 is the value being read. When another source outranks transmit empty, the flag is left alone.
- R9: When `auto_cts` is 0, a modem status event is reported if enable bit 3 is set. When `auto_cts` is 1, it is reported only if enable bits 3 and 7 are both set.
- R10: Identification bit 9 reports auto-baud time-out, gated by enable bit 8. Identification bit 8 reports auto-baud done, gated by enable bit 9. Either one also clears bit 0.
- R11: Enable bits other than 0–3 and 7–9 read as 0 and ignore writes. Writes to address 1 change nothing, and other addresses read 0.
- R12: An event or clear sampled at clock edge N shows up in the identification read data and in `irq` after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address: 0 enable, 1 identification |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; held high for the whole access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from address |
| src_evt | input | 7 | One-cycle event pulse per source |
| src_clr | input | 7 | One-cycle clear pulse per source |
| auto_cts | input | 1 | Auto clear-to-send flow control is active |
| irq | output | 1 | Interrupt request, active high |

## Verification
An event or clear sampled at edge N reaches the pending flag at N and the snapshot at N+1. The bench therefore drives every pulse two nanoseconds after an edge and starts a read no earlier than the edge after that. Read data is valid in the cycle of the strobe. The monitor compares the value popped from the scoreboard at the falling edge of the first read cycle, and checks each extra cycle of a held read for an unchanged value. The latency of `irq` is checked directly: it is still low at the falling edge that follows the capture edge, and high one cycle later.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 7;
  localparam int EN_W = 10;

  // source indices
  localparam int SRC_RLS  = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_CTI  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MSI  = 4;
  localparam int SRC_ABTO = 5;
  localparam int SRC_ABEO = 6;

  // enable bit positions
  localparam int EN_RDA  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_RLS  = 2;
  localparam int EN_MSI  = 3;
  localparam int EN_CTS  = 7;
  localparam int EN_ABTO = 8;
  localparam int EN_ABEO = 9;
  localparam logic [EN_W-1:0] EN_MASK = 10'h38F;

  // identification fields
  localparam int IDB_ABEO = 8;
  localparam int IDB_ABTO = 9;

  typedef enum logic [2:0] {
    CODE_MSI  = 3'b000,
    CODE_THRE = 3'b001,
    CODE_RDA  = 3'b010,
    CODE_RLS  = 3'b011,
    CODE_CTI  = 3'b110
  } irq_code_e;
endpackage

// File: rtl/uirq_enable.sv
module uirq_enable
  import uirq_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter int EN_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en_q
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (wr_en && reg_addr == A_EN)
      en_q <= wdata[EN_W-1:0] & EN_MASK;
  end
endmodule

// File: rtl/uirq_pending.sv
module uirq_pending
  import uirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] rd_clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[i] <= 1'b0;
      else if (evt[i])
        pend[i] <= 1'b1;
      else if (clr[i] || rd_clr[i])
        pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_gate.sv
module uirq_gate
  import uirq_pkg::*;
(
  input  logic [EN_W-1:0] en_q,
  input  logic            auto_cts,
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] masked
);
  logic [NSRC-1:0] eff;

  always_comb begin
    eff           = '0;
    eff[SRC_RLS]  = en_q[EN_RLS];
    eff[SRC_RDA]  = en_q[EN_RDA];
    eff[SRC_CTI]  = en_q[EN_RDA];
    eff[SRC_THRE] = en_q[EN_THRE];
    eff[SRC_MSI]  = en_q[EN_MSI] & (~auto_cts | en_q[EN_CTS]);
    eff[SRC_ABTO] = en_q[EN_ABTO];
    eff[SRC_ABEO] = en_q[EN_ABEO];
    masked        = pend & eff;
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NSRC-1:0]   masked,
  output logic [DATA_W-1:0] ident
);
  irq_code_e code;

  always_comb begin
    if (masked[SRC_RLS])       code = CODE_RLS;
    else if (masked[SRC_RDA])  code = CODE_RDA;
    else if (masked[SRC_CTI])  code = CODE_CTI;
    else if (masked[SRC_THRE]) code = CODE_THRE;
    else                       code = CODE_MSI;
    ident           = '0;
    ident[0]        = ~|masked;
    ident[3:1]      = code;
    ident[IDB_ABEO] = masked[SRC_ABEO];
    ident[IDB_ABTO] = masked[SRC_ABTO];
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter int EN_ADDR = 0,
  parameter int ID_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NSRC-1:0]   src_clr,
  input  logic              auto_cts,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] A_ID = ADDR_W'(ID_ADDR);

  logic [EN_W-1:0]   en_q;
  logic [NSRC-1:0]   pend, masked, rd_clr;
  logic [DATA_W-1:0] ident_live, ident_q;
  logic              rd_id, rd_id_d, rd_start;

  assign rd_id    = rd_en && (reg_addr == A_ID);
  assign rd_start = rd_id && !rd_id_d;

  always_comb begin
    rd_clr           = '0;
    rd_clr[SRC_THRE] = rd_start && !ident_q[0] && (ident_q[3:1] == CODE_THRE);
  end

  uirq_enable #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EN_ADDR)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wdata(wdata), .en_q(en_q)
  );

  uirq_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr(src_clr),
    .rd_clr(rd_clr), .pend(pend)
  );

  uirq_gate u_gate (
    .en_q(en_q), .auto_cts(auto_cts), .pend(pend), .masked(masked)
  );

  uirq_prio #(.DATA_W(DATA_W)) u_prio (
    .masked(masked), .ident(ident_live)
  );

  // snapshot frozen for the length of an identification read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= DATA_W'(1);
      rd_id_d <= 1'b0;
    end else begin
      rd_id_d <= rd_id;
      if (!rd_id) ident_q <= ident_live;
    end
  end

  assign irq = ~ident_q[0];

  always_comb begin
    rdata = '0;
    if (reg_addr == A_EN)      rdata = DATA_W'(en_q);
    else if (reg_addr == A_ID) rdata = ident_q;
  end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter int EN_ADDR = 0,
  parameter int ID_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [NSRC-1:0]   src_evt,
  input logic              irq,
  input logic [NSRC-1:0]   pend,
  input logic [DATA_W-1:0] ident_q
);
  logic rd_id;
  assign rd_id = rd_en && (reg_addr == ADDR_W'(ID_ADDR));

  AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((pend & $past(src_evt)) == $past(src_evt))); // R2

  AST_IRQ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |-> (irq == !rdata[0])); // R5

  AST_FROZEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && $past(rd_id)) |-> $stable(ident_q)); // R6

  AST_THRE_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && !$past(rd_id) && !ident_q[0] && ident_q[3:1] == 3'b001
     && !src_evt[SRC_THRE]) |=> !pend[SRC_THRE]); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == ADDR_W'(EN_ADDR))
      |-> (rdata[6:4] == 3'b000 && rdata[DATA_W-1:EN_W] == '0)); // R11
endmodule

bind uart_irq_ident uirq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EN_ADDR), .ID_ADDR(ID_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en),
  .rdata(rdata), .src_evt(src_evt), .irq(irq), .pend(pend),
  .ident_q(ident_q)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  reg_addr = 0;
  logic        wr_en = 0, rd_en = 0, auto_cts = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [6:0]  src_evt = 0, src_clr = 0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_rd = 0;

  always #10 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .src_evt(src_evt),
    .src_clr(src_clr), .auto_cts(auto_cts), .irq(irq)
  );

  // monitor: first cycle of each read pops the scoreboard
  always @(negedge clk) begin
    if (rd_en && !prev_rd) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty rdata=%h", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s rdata=%h exp=%h", t, rdata, e);
        end
      end
    end
    prev_rd = rd_en;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #2 rd_en = 1; reg_addr = a;
    @(posedge clk); #2 rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2 wr_en = 1; reg_addr = a; wdata = d;
    @(posedge clk); #2 wr_en = 0;
  endtask

  task automatic evt(input int i);
    @(posedge clk); #2 src_evt[i] = 1;
    @(posedge clk); #2 src_evt = 0;
  endtask

  task automatic clr(input int i);
    @(posedge clk); #2 src_clr[i] = 1;
    @(posedge clk); #2 src_clr = 0;
  endtask

  task automatic irq_is(input logic e, input string t);
    @(posedge clk); @(negedge clk);
    chk({31'b0, irq}, {31'b0, e}, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd(1, 32'h001, "R1 ident reset");
    rd(0, 32'h000, "R1 enable reset");
    irq_is(0, "R1 irq reset");

    // R3 masked source not reported; R12 latency
    evt(1);
    rd(1, 32'h001, "R3 masked data-available");
    wr(0, 32'h7);
    rd(1, 32'h004, "R3 R4 data-available code 010");
    irq_is(1, "R5 irq with pending");
    // R4 priority
    evt(0);
    rd(1, 32'h006, "R4 line status code 011");
    clr(0);
    rd(1, 32'h004, "R2 clear line status");
    clr(1);
    rd(1, 32'h001, "R2 clear data-available");
    irq_is(0, "R5 irq released");
    evt(2);
    rd(1, 32'h00C, "R4 time-out code 110");
    clr(2);

    // R12 exact latency on irq
    @(posedge clk); #2 src_evt[0] = 1;
    @(posedge clk); #2 src_evt = 0;
    @(negedge clk); chk({31'b0, irq}, 32'h0, "R12 irq not yet");
    @(negedge clk); chk({31'b0, irq}, 32'h1, "R12 irq due");
    clr(0);

    // R8 transmit-empty cleared by read
    evt(3);
    rd(1, 32'h002, "R8 transmit-empty code 001");
    rd(1, 32'h001, "R8 cleared by read");
    evt(1); evt(3);
    rd(1, 32'h004, "R8 outranked read");
    clr(1);
    rd(1, 32'h002, "R8 not cleared when hidden");
    rd(1, 32'h001, "R8 cleared after report");

    // R9 CTS gating
    wr(0, 32'h0F);
    evt(4);
    rd(1, 32'h000, "R9 modem no auto-cts");
    clr(4);
    #0 auto_cts = 1;
    evt(4);
    rd(1, 32'h001, "R9 auto-cts needs bit 7");
    wr(0, 32'h8F);
    rd(1, 32'h000, "R9 auto-cts with bit 7");
    clr(4);
    auto_cts = 0;

    // R11 reserved bits and read-only ident
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h38F, "R11 reserved read 0");
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h001, "R11 ident write ignored");
    rd(2, 32'h000, "R11 unused address");

    // R10 auto-baud bits
    wr(0, 32'h300);
    evt(5);
    rd(1, 32'h200, "R10 auto-baud time-out bit 9");
    evt(6);
    rd(1, 32'h300, "R10 auto-baud done bit 8");
    clr(5); clr(6);
    wr(0, 32'h100);
    evt(6);
    rd(1, 32'h001, "R10 done masked by enable bit 9");
    clr(6);

    // R6 R7 frozen read and held event
    wr(0, 32'h7);
    evt(1);
    exp_q.push_back(32'h004); tag_q.push_back("R6 held read first cycle");
    @(posedge clk); #2 rd_en = 1; reg_addr = 1; src_evt[0] = 1;
    @(posedge clk); #2 src_evt = 0;
    @(negedge clk); chk(rdata, 32'h004, "R6 frozen cycle 2");
    @(posedge clk); @(negedge clk);
    chk(rdata, 32'h004, "R6 frozen cycle 3");
    chk({31'b0, irq}, 32'h1, "R6 irq frozen");
    @(posedge clk); #2 rd_en = 0;
    rd(1, 32'h006, "R7 event kept for next read");
    // R2 event wins over same-cycle clear
    @(posedge clk); #2 src_evt[2] = 1; src_clr[2] = 1;
    @(posedge clk); #2 src_evt = 0; src_clr = 0;
    clr(0); clr(1);
    rd(1, 32'h00C, "R2 event beats clear");

    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule